// File: doc/BRIEF.md
# Vectored Interrupt Controller with Stack Gating

This block decides when a small 8-bit core must break off its program to serve an interrupt, and where it must jump. It watches three sources: a falling edge on an external pin, a one-cycle overflow pulse from a timer, and a one-cycle end-of-conversion pulse from an A/D converter. Each source owns a sticky request flag and an enable bit. One global enable gates all three. Software reads and writes all of these bits through one control register.

When the global enable is set, a flag is pending with its enable set, and the call stack has room, the block raises a call request to the core. It also presents the vector of the highest-priority pending source. The core answers with a one-cycle acknowledge while it pushes only its program counter and jumps. On that acknowledge the block clears the serviced flag and the global enable, so no second interrupt can nest unless software re-arms it. Requests that arrive during service still latch their flags. Any enabled pending flag also drives a wake signal to the halt logic, whether or not the global enable is set and whether or not the stack is full.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A high-to-low transition on `ext_pin` sets the external flag (control register bit 4) a few cycles later, after two synchronizer stages. A low-to-high transition sets no flag.
- R2: A one-cycle high pulse on `tmr_ovf` sets the timer flag (bit 5). A one-cycle high pulse on `adc_eoc` sets the A/D flag (bit 6).
- R3: The control register layout is: bit 0 global enable, bits 1/2/3 enables for external/timer/A/D, bits 4/5/6 flags for external/timer/A/D, and bit 7 always reads 0. A write loads bits 6..0 as written.
- R4: `irq_call` is high exactly when the global enable is set, at least one flag is set together with its enable, and `stack_full` is low. After reset the register reads 0 and `irq_call` and `wake` are low.
- R5: `irq_vector` is 0x04 for the external source, 0x08 for the timer and 0x0C for the A/D. When several enabled flags are pending, the external source wins first, then the timer, then the A/D.
- R6: When `irq_ack` is high while `irq_call` is high, the next register value has the serviced flag and the global enable cleared. All other bits are kept.
- R7: While the global enable is clear, source events still set their flags, but `irq_call` stays low.
- R8: While `stack_full` is high, `irq_call` stays low. It rises again in the same cycle that `stack_full` falls, provided the request is still pending.
- R9: `wake` is high whenever any flag is set together with its own enable. This holds regardless of the global enable and of `stack_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | External interrupt pin, falling-edge sensitive |
| tmr_ovf | input | 1 | Timer overflow pulse |
| adc_eoc | input | 1 | A/D end-of-conversion pulse |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| stack_full | input | 1 | Call stack has no free entry |
| irq_call | output | 1 | Request to the core to push the PC and jump |
| irq_vector | output | 11 | Jump target of the request |
| irq_ack | input | 1 | Core accepts the call this cycle |
| wake | output | 1 | Wake-up request to the halt logic |

## Verification
The main function is exercised by a table of register images. Some images have one pending source and show that each source gets its own vector. Some have several pending sources and show the priority order. One has a pending but disabled source, which separates a flag from an enabled request. Others clear the global enable or raise `stack_full`, which separates the `irq_call` gate from the `wake` path. Directed cases then show that falling edges are caught and rising edges are not, and that an acknowledge clears exactly one flag plus the global enable. They also show that flags latch while the global enable is off, and that a blocked request resumes when the stack frees up.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int IRQ_SRC_N = 3;
   localparam int SRC_EXT   = 0;
   localparam int SRC_TMR   = 1;
   localparam int SRC_ADC   = 2;
endpackage

// File: rtl/irq_fall_detect.sv
module irq_fall_detect #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);
   logic synced;
   logic prev;

   generate
      if (STAGES < 0) begin : g_bad_stages
         $fatal(1, "STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_direct
         assign synced = pin;
      end else begin : g_sync
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sh <= '1;
            end else begin
               sh[0] <= pin;
               for (int i = 1; i < STAGES; i++) begin
                  sh[i] <= sh[i-1];
               end
            end
         end
         assign synced = sh[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= synced;
   end

   assign fall = prev & ~synced;
endmodule

// File: rtl/irq_prio_vec.sv
module irq_prio_vec #(
   parameter int N          = 3,
   parameter int PC_W       = 11,
   parameter int VEC_BASE   = 4,
   parameter int VEC_STRIDE = 4
) (
   input  logic [N-1:0]    pend,
   output logic [N-1:0]    grant,
   output logic [PC_W-1:0] vector
);
   localparam int VEC_TOP = VEC_BASE + (N - 1) * VEC_STRIDE;

   generate
      if (VEC_TOP >= (1 << PC_W)) begin : g_bad_vec
         $fatal(1, "vector table does not fit in PC_W bits");
      end
   endgenerate

   // lowest index wins: scan from the top so the last hit stays
   always_comb begin
      grant  = '0;
      vector = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            vector   = PC_W'(VEC_BASE + i * VEC_STRIDE);
         end
      end
   end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
   parameter int N     = 3,
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic [N-1:0]     evt,
   input  logic             ack_fire,
   input  logic [N-1:0]     grant,
   output logic             master,
   output logic [N-1:0]     en,
   output logic [N-1:0]     flag,
   output logic [REG_W-1:0] rdata
);
   localparam int EN_LSB   = 1;
   localparam int FLAG_LSB = 1 + N;
   localparam int USED     = 1 + 2 * N;

   logic          m_nx;
   logic [N-1:0]  en_nx;
   logic [N-1:0]  f_nx;

   generate
      if (USED > REG_W) begin : g_bad_width
         $fatal(1, "control register too narrow for source count");
      end
      if (USED < REG_W) begin : g_pad
         logic unused_hi;
         assign unused_hi = ^wdata[REG_W-1:USED];
      end
   endgenerate

   // order: software write, then hardware clear on accept, then new events win
   always_comb begin
      m_nx  = master;
      en_nx = en;
      f_nx  = flag;
      if (wr) begin
         m_nx  = wdata[0];
         en_nx = wdata[EN_LSB +: N];
         f_nx  = wdata[FLAG_LSB +: N];
      end
      if (ack_fire) begin
         m_nx = 1'b0;
         f_nx = f_nx & ~grant;
      end
      f_nx = f_nx | evt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         master <= 1'b0;
         en     <= '0;
         flag   <= '0;
      end else begin
         master <= m_nx;
         en     <= en_nx;
         flag   <= f_nx;
      end
   end

   always_comb begin
      rdata                  = '0;
      rdata[0]               = master;
      rdata[EN_LSB +: N]     = en;
      rdata[FLAG_LSB +: N]   = flag;
   end

   generate
      for (genvar g = 0; g < N; g++) begin : g_chk
         p_evt_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> flag[g]);
      end
   endgenerate

   p_ack_drops_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && !wr) |=> !master);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_pkg::*;
#(
   parameter int REG_W       = 8,
   parameter int PC_W        = 11,
   parameter int VEC_BASE    = 4,
   parameter int VEC_STRIDE  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_pin,
   input  logic             tmr_ovf,
   input  logic             adc_eoc,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             stack_full,
   output logic             irq_call,
   output logic [PC_W-1:0]  irq_vector,
   input  logic             irq_ack,
   output logic             wake
);
   localparam int N = IRQ_SRC_N;

   logic           ext_fall;
   logic [N-1:0]   evt;
   logic           master;
   logic [N-1:0]   en;
   logic [N-1:0]   flag;
   logic [N-1:0]   pend;
   logic [N-1:0]   grant;
   logic           ack_fire;

   irq_fall_detect #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ext_pin),
      .fall  (ext_fall)
   );

   always_comb begin
      evt          = '0;
      evt[SRC_EXT] = ext_fall;
      evt[SRC_TMR] = tmr_ovf;
      evt[SRC_ADC] = adc_eoc;
   end

   irq_ctrl_reg #(.N(N), .REG_W(REG_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .wdata    (reg_wdata),
      .evt      (evt),
      .ack_fire (ack_fire),
      .grant    (grant),
      .master   (master),
      .en       (en),
      .flag     (flag),
      .rdata    (reg_rdata)
   );

   assign pend = flag & en;

   irq_prio_vec #(
      .N          (N),
      .PC_W       (PC_W),
      .VEC_BASE   (VEC_BASE),
      .VEC_STRIDE (VEC_STRIDE)
   ) u_prio (
      .pend   (pend),
      .grant  (grant),
      .vector (irq_vector)
   );

   assign irq_call = master & ~stack_full & (|pend);
   assign wake     = |pend;
   assign ack_fire = irq_ack & irq_call;

   p_stack_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stack_full |-> !irq_call);

   p_master_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[0] |-> !irq_call);

   p_call_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_call |-> wake);

   p_ext_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_call && reg_rdata[1] && reg_rdata[4]) |-> (irq_vector == PC_W'(VEC_BASE)));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_pin = 1'b1;
   logic        tmr_ovf = 1'b0;
   logic        adc_eoc = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        stack_full = 1'b0;
   logic        irq_call;
   logic [10:0] irq_vector;
   logic        irq_ack = 1'b0;
   logic        wake;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   irq_vector_ctrl u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_pin    (ext_pin),
      .tmr_ovf    (tmr_ovf),
      .adc_eoc    (adc_eoc),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .stack_full (stack_full),
      .irq_call   (irq_call),
      .irq_vector (irq_vector),
      .irq_ack    (irq_ack),
      .wake       (wake)
   );

   // entry: {wdata[20:13], stack_full[12], call[11], wake[10], vector[9:0]}
   localparam logic [20:0] TBL [8] = '{
      {8'h7F, 1'b0, 1'b1, 1'b1, 10'h004},
      {8'h6D, 1'b0, 1'b1, 1'b1, 10'h008},
      {8'h49, 1'b0, 1'b1, 1'b1, 10'h00C},
      {8'h7E, 1'b0, 1'b0, 1'b1, 10'h000},
      {8'h7F, 1'b1, 1'b0, 1'b1, 10'h000},
      {8'h71, 1'b0, 1'b0, 1'b0, 10'h000},
      {8'h6B, 1'b0, 1'b1, 1'b1, 10'h00C},
      {8'h13, 1'b0, 1'b1, 1'b1, 10'h004}
   };

   task automatic chk(input string req, input int got, input int exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] d);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #800000;
      total++;
      bad++;
      $display("FAIL watchdog got=hang exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R4 reset state
      chk("R4 reset rdata", reg_rdata, 0);
      chk("R4 reset call", irq_call, 0);
      chk("R9 reset wake", wake, 0);

      // table walk: R3 R4 R5 R7 R8 R9
      for (int k = 0; k < 8; k++) begin
         stack_full = TBL[k][12];
         wr_reg(TBL[k][20:13]);
         chk("R3 table rdata", reg_rdata, int'(TBL[k][20:13] & 8'h7F));
         chk("R4 table call", irq_call, TBL[k][11]);
         chk("R9 table wake", wake, TBL[k][10]);
         if (TBL[k][11]) chk("R5 table vector", irq_vector, int'(TBL[k][9:0]));
      end
      stack_full = 1'b0;

      // R3 bit 7 reads zero
      wr_reg(8'hFF);
      chk("R3 bit7 zero", reg_rdata, 8'h7F);

      // R1 falling edge
      wr_reg(8'h00);
      ext_pin = 1'b0;
      idle(5);
      chk("R1 fall sets bit4", reg_rdata, 8'h10);
      // R1 rising edge ignored
      wr_reg(8'h00);
      ext_pin = 1'b1;
      idle(5);
      chk("R1 rise ignored", reg_rdata, 8'h00);

      // R2 pulses
      tmr_ovf = 1'b1;
      @(negedge clk);
      tmr_ovf = 1'b0;
      @(negedge clk);
      chk("R2 timer bit5", reg_rdata, 8'h20);
      adc_eoc = 1'b1;
      @(negedge clk);
      adc_eoc = 1'b0;
      @(negedge clk);
      chk("R2 adc bit6", reg_rdata, 8'h60);

      // R6 acknowledge
      wr_reg(8'h7F);
      chk("R6 pre call", irq_call, 1);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      chk("R6 after ack rdata", reg_rdata, 8'h6E);
      chk("R6 after ack call", irq_call, 0);

      // R7 flags latch with master off
      wr_reg(8'h0E);
      adc_eoc = 1'b1;
      @(negedge clk);
      adc_eoc = 1'b0;
      @(negedge clk);
      chk("R7 latch rdata", reg_rdata, 8'h4E);
      chk("R7 no call", irq_call, 0);
      chk("R9 wake master off", wake, 1);

      // R8 stack full then resume
      stack_full = 1'b1;
      wr_reg(8'h13);
      chk("R8 blocked call", irq_call, 0);
      chk("R9 wake stack full", wake, 1);
      stack_full = 1'b0;
      #1;
      chk("R8 resume call", irq_call, 1);
      chk("R8 resume vector", irq_vector, 11'h004);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule